// File: doc/BRIEF.md
# Card Clock Divider with Frequency Limit Check

This block generates the clock driven onto a contact smart card. It runs from an internal clock at twice the crystal frequency, so a half period of one internal cycle gives a card clock equal to the crystal. The card clock is the crystal divided by 1, 2, 4 or 8. After reset the block divides by 4, which gives about 3.69 MHz from a 14.745 MHz crystal.

Software selects a new division with a one-cycle request. The request carries an 8-bit code and the 4-bit Fi index that the card reported. The block checks the code first. It then compares the resulting card frequency, in kHz, against the highest frequency that the Fi index allows. It answers every request one cycle later with a status. An accepted division waits until the current low phase of the card clock has ended, and it takes effect from the next rising edge. On that edge a one-cycle strobe tells the waiting-time counters to rescale.

Top module: `card_clk_divider`

## Requirements
- R1: After reset the card clock output is low, no strobe or response is asserted, and the card clock runs at division 4: a period of 8 internal cycles with 4 cycles high.
- R2: An accepted code 0x00, 0x02, 0x04 or 0x06 selects division 1, 2, 4 or 8. Once the change is applied, each card clock period is 2×division internal cycles.
- R3: A code that has any of bits 7..3 set, or has bit 0 set, is rejected with status 2'b01 (bad code). This test takes precedence over the frequency test.
- R4: With Fi index 0, 1 or 2 (Fi 372, 372, 558) the limit is 6000 kHz. Codes 0x00 and 0x02 are then rejected with status 2'b10 (too fast).
- R5: The card frequency for a valid code is 14745 kHz divided by the division, rounded down. Limits in kHz per Fi index are: 3→8000, 4→12000, 5→16000, 6→20000, 9→5000, 10→7500, 11→10000, 12→15000, 13→20000. Indices 7, 8, 14 and 15 have a limit of 0. A frequency above the limit gives status 2'b10.
- R6: resp_valid is high exactly in the cycle after a request cycle. An accepted request reports status 2'b00.
- R7: The division changes only when a low phase ends. Every high or low phase of the card clock lasts 1, 2, 4 or 8 internal cycles, with no shorter runt phase.
- R8: rescale_stb pulses for one cycle on the rising card clock edge where a new division starts. Several accepts before that edge give a single strobe, and the last accepted division wins.
- R9: A rejected request leaves the running division and any pending division unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the crystal rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle division request |
| req_code | input | 8 | Division select code |
| req_fi | input | 4 | Fi index of the card |
| card_clk | output | 1 | Clock to the card |
| rescale_stb | output | 1 | One-cycle pulse when a new division starts |
| resp_valid | output | 1 | Response valid, one cycle after a request |
| resp_status | output | 2 | 00 accepted, 01 bad code, 10 too fast |

## Verification
The tests try all four valid codes against Fi indices from several limit classes:
- Indices 0 and 4 reject only the fast codes.
- Indices 9 and 10 sit either side of the 7372 kHz frequency that division 2 gives, so they show whether the comparison is strict.
- Index 5 accepts division 1.
- Reserved indices reject every code.

Malformed codes, including one sent with a reserved Fi index, check that the code test runs first. After each reject, a period measurement shows that the running division did not change.

Two accepts are issued just after a rising edge, before the switch can happen. This tells apart a design that keeps the last request from one that applies both or emits two strobes. High-phase measurements then show that the new division starts cleanly at the rising edge.

// File: rtl/ccd_pkg.sv
// Shared types for the card clock divider.
// Assumes: status encoding is fixed and visible at the top ports.
package ccd_pkg;

    typedef enum logic [1:0] {
        CCD_OK       = 2'b00,
        CCD_BAD_CODE = 2'b01,
        CCD_TOO_FAST = 2'b10
    } ccd_status_e;

endpackage

// File: rtl/ccd_fmax_lut.sv
// Maximum card clock frequency in kHz for a given Fi index.
// Assumes: indices without a defined limit return 0, so every division fails.
module ccd_fmax_lut #(
    parameter int FI_W  = 4,
    parameter int LIM_W = 16
) (
    input  logic [FI_W-1:0]  fi_idx,
    output logic [LIM_W-1:0] fmax_khz
);

    // Map the Fi index to its frequency ceiling.
    always_comb begin
        case (int'(fi_idx))
            0, 1, 2: fmax_khz = LIM_W'(6000);
            3:       fmax_khz = LIM_W'(8000);
            4:       fmax_khz = LIM_W'(12000);
            5:       fmax_khz = LIM_W'(16000);
            6:       fmax_khz = LIM_W'(20000);
            9:       fmax_khz = LIM_W'(5000);
            10:      fmax_khz = LIM_W'(7500);
            11:      fmax_khz = LIM_W'(10000);
            12:      fmax_khz = LIM_W'(15000);
            13:      fmax_khz = LIM_W'(20000);
            default: fmax_khz = '0;
        endcase
    end

endmodule

// File: rtl/ccd_req_check.sv
// Decodes a division request, checks it against the Fi frequency limit,
// and registers both the response and the accepted selection.
// Assumes: code bits [SEL_W:1] hold the division exponent and every other bit must be zero.
module ccd_req_check #(
    parameter int CODE_W   = 8,
    parameter int FI_W     = 4,
    parameter int SEL_W    = 2,
    parameter int LIM_W    = 16,
    parameter int XTAL_KHZ = 14745
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CODE_W-1:0]    req_code,
    input  logic [FI_W-1:0]      req_fi,
    output logic                 resp_valid,
    output ccd_pkg::ccd_status_e resp_status,
    output logic                 acc_valid,
    output logic [SEL_W-1:0]     acc_sel
);

    localparam int NUM_DIV = 1 << SEL_W;

    logic [LIM_W-1:0] freq_tab [NUM_DIV];
    logic [LIM_W-1:0] fmax_khz;
    logic             code_ok;
    logic [SEL_W-1:0] sel;
    logic             too_fast;
    ccd_pkg::ccd_status_e verdict;

    // One entry per division: the crystal frequency shifted down.
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_freq
        assign freq_tab[g] = LIM_W'(XTAL_KHZ >> g);
    end

    ccd_fmax_lut #(.FI_W(FI_W), .LIM_W(LIM_W)) lut_i (
        .fi_idx   (req_fi),
        .fmax_khz (fmax_khz)
    );

    // Code validity, division exponent and the limit comparison.
    always_comb begin
        code_ok  = ((req_code >> (SEL_W + 1)) == '0) && !req_code[0];
        sel      = req_code[SEL_W:1];
        too_fast = freq_tab[sel] > fmax_khz;
        if (!code_ok)      verdict = ccd_pkg::CCD_BAD_CODE;
        else if (too_fast) verdict = ccd_pkg::CCD_TOO_FAST;
        else               verdict = ccd_pkg::CCD_OK;
    end

    // Register the response and the selection handed to the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= ccd_pkg::CCD_OK;
            acc_valid   <= 1'b0;
            acc_sel     <= '0;
        end else begin
            resp_valid <= req_valid;
            acc_valid  <= req_valid && (verdict == ccd_pkg::CCD_OK);
            if (req_valid) begin
                resp_status <= verdict;
                acc_sel     <= sel;
            end
        end
    end

endmodule

// File: rtl/ccd_clk_gen.sv
// Half-period counter that toggles the card clock. A new division is held
// pending and loaded only when a low phase ends, so the new division starts
// on a rising edge and no phase is cut short.
// Assumes: the half period is 2**sel internal cycles.
module ccd_clk_gen #(
    parameter int SEL_W   = 2,
    parameter int RST_SEL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SEL_W-1:0] acc_sel,
    output logic             card_clk,
    output logic             rescale_stb
);

    localparam int NUM_DIV = 1 << SEL_W;
    localparam int HCNT_W  = (NUM_DIV > 1) ? NUM_DIV - 1 : 1;

    logic [HCNT_W-1:0] hcnt;
    logic [HCNT_W:0]   half;
    logic [SEL_W-1:0]  act_sel;
    logic [SEL_W-1:0]  pend_sel;
    logic              pend_v;
    logic              end_ph;

    // Half-period length and the end-of-phase condition.
    always_comb begin
        half   = (HCNT_W + 1)'(1) << act_sel;
        end_ph = ({1'b0, hcnt} == (half - 1'b1));
    end

    // Phase counting, clock toggling, pending capture and switch-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt        <= '0;
            card_clk    <= 1'b0;
            act_sel     <= SEL_W'(RST_SEL);
            pend_sel    <= '0;
            pend_v      <= 1'b0;
            rescale_stb <= 1'b0;
        end else begin
            rescale_stb <= 1'b0;
            if (end_ph) begin
                hcnt     <= '0;
                card_clk <= ~card_clk;
                if (!card_clk && pend_v) begin
                    act_sel     <= pend_sel;
                    pend_v      <= 1'b0;
                    rescale_stb <= 1'b1;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
            if (acc_valid) begin
                pend_v   <= 1'b1;
                pend_sel <= acc_sel;
            end
        end
    end

endmodule

// File: rtl/card_clk_divider.sv
// Top level: the request checker feeds the glitch-free card clock divider.
// Assumes: clk runs at twice the crystal rate and the reset is synchronous.
module card_clk_divider #(
    parameter int CODE_W   = 8,
    parameter int FI_W     = 4,
    parameter int SEL_W    = 2,
    parameter int LIM_W    = 16,
    parameter int XTAL_KHZ = 14745,
    parameter int RST_SEL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  logic [FI_W-1:0]   req_fi,
    output logic              card_clk,
    output logic              rescale_stb,
    output logic              resp_valid,
    output logic [1:0]        resp_status
);

    ccd_pkg::ccd_status_e status_q;
    logic                 acc_valid;
    logic [SEL_W-1:0]     acc_sel;

    ccd_req_check #(
        .CODE_W(CODE_W), .FI_W(FI_W), .SEL_W(SEL_W),
        .LIM_W(LIM_W), .XTAL_KHZ(XTAL_KHZ)
    ) chk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_code    (req_code),
        .req_fi      (req_fi),
        .resp_valid  (resp_valid),
        .resp_status (status_q),
        .acc_valid   (acc_valid),
        .acc_sel     (acc_sel)
    );

    ccd_clk_gen #(.SEL_W(SEL_W), .RST_SEL(RST_SEL)) gen_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_sel     (acc_sel),
        .card_clk    (card_clk),
        .rescale_stb (rescale_stb)
    );

    assign resp_status = status_q;

endmodule

// File: rtl/card_clk_divider_chk.sv
// Property checker for the card clock divider, bound to the top module.
// Assumes: the default 8-bit code and 4-bit Fi index layout.
module card_clk_divider_chk #(
    parameter int MAX_HALF = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [7:0] req_code,
    input logic [3:0] req_fi,
    input logic       card_clk,
    input logic       rescale_stb,
    input logic       resp_valid,
    input logic [1:0] resp_status
);

    logic       prev_clk;
    logic [7:0] run;
    logic       chg;
    logic       req_bad;
    logic       req_fast_slowfi;

    assign chg             = card_clk != prev_clk;
    assign req_bad         = req_valid && ((req_code[7:3] != 5'd0) || req_code[0]);
    assign req_fast_slowfi = req_valid && (req_fi <= 4'd2) &&
                             ((req_code == 8'h00) || (req_code == 8'h02));

    // Count the cycles spent at the current card clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_clk <= 1'b0;
            run      <= 8'd0;
        end else begin
            prev_clk <= card_clk;
            run      <= chg ? 8'd1 : run + 8'd1;
        end
    end

    // R7
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> ($onehot(run) && (run <= 8'(MAX_HALF))));

    // R8
    stb_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rescale_stb |-> $rose(card_clk));

    // R6
    resp_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (resp_valid == $past(req_valid)));

    // R3
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_bad |=> (resp_status == 2'b01));

    // R4
    slow_fi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_fast_slowfi |=> (resp_status == 2'b10));

endmodule

bind card_clk_divider card_clk_divider_chk chk_bind_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_code    (req_code),
    .req_fi      (req_fi),
    .card_clk    (card_clk),
    .rescale_stb (rescale_stb),
    .resp_valid  (resp_valid),
    .resp_status (resp_status)
);

// File: tb/card_clk_divider_tb_top.sv
module card_clk_divider_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [7:0] req_code;
    logic [3:0] req_fi;
    logic       card_clk;
    logic       rescale_stb;
    logic       resp_valid;
    logic [1:0] resp_status;

    int vec = 0;
    int bad = 0;
    int stb_cnt = 0;
    bit run_cmp = 0;

    // reference model state
    int m_clk, m_cnt, m_half, m_pend, m_stb, m_rv, m_st, m_acc_v, m_acc_half;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_clk_divider dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_fi(req_fi), .card_clk(card_clk), .rescale_stb(rescale_stb),
        .resp_valid(resp_valid), .resp_status(resp_status)
    );

    function automatic int fmax_of(input int fi);
        case (fi)
            0, 1, 2: return 6000;
            3: return 8000;
            4: return 12000;
            5: return 16000;
            6: return 20000;
            9: return 5000;
            10: return 7500;
            11: return 10000;
            12: return 15000;
            13: return 20000;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_status(input int code, input int fi);
        int div;
        if (!(code == 0 || code == 2 || code == 4 || code == 6)) return 1;
        div = 1 << (code / 2);
        if ((14745 / div) > fmax_of(fi)) return 2;
        return 0;
    endfunction

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_clk = 0; m_cnt = 0; m_half = 4; m_pend = 0;
            m_stb = 0; m_rv = 0; m_st = 0; m_acc_v = 0; m_acc_half = 0;
        end else begin
            m_stb = 0;
            if (m_cnt == m_half - 1) begin
                m_cnt = 0;
                if (m_clk == 0 && m_pend > 0) begin
                    m_half = m_pend;
                    m_pend = 0;
                    m_stb  = 1;
                end
                m_clk = 1 - m_clk;
            end else begin
                m_cnt++;
            end
            if (m_acc_v) m_pend = m_acc_half;
            m_rv = req_valid;
            if (req_valid) m_st = exp_status(req_code, req_fi);
            m_acc_v = req_valid && (exp_status(req_code, req_fi) == 0);
            m_acc_half = 1 << (req_code / 2);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design against the model on every clock.
    always @(negedge clk) begin
        if (run_cmp) begin
            check("R7 card_clk vs model", int'(card_clk), m_clk);
            check("R8 rescale_stb vs model", int'(rescale_stb), m_stb);
            check("R6 resp_valid vs model", int'(resp_valid), m_rv);
            if (m_rv) check("R6 resp_status vs model", int'(resp_status), m_st);
            if (rescale_stb) stb_cnt++;
        end
    end

    task automatic send(input logic [7:0] c, input logic [3:0] f, input int exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_code = c; req_fi = f;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " resp_valid"}, int'(resp_valid), 1);
        check({tag, " status"}, int'(resp_status), exp);
    endtask

    task automatic wait_rise();
        logic p;
        p = card_clk;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (card_clk && !p) break;
            p = card_clk;
        end
    endtask

    task automatic measure(input int div, input string tag);
        int per, hi;
        logic p;
        wait_rise();
        per = 0; hi = 1; p = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            per++;
            if (card_clk && !p) break;
            if (card_clk) hi++;
            p = card_clk;
        end
        check({tag, " period"}, per, 2 * div);
        check({tag, " R7 high phase"}, hi, div);
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int s0;
        rst_n = 1'b0; req_valid = 1'b0; req_code = 8'h00; req_fi = 4'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run_cmp = 1;
        // R1: reset state and default division
        check("R1 card_clk low", int'(card_clk), 0);
        check("R1 no strobe", int'(rescale_stb), 0);
        check("R1 no response", int'(resp_valid), 0);
        measure(4, "R1 default div4");

        // R4: slow Fi classes refuse division 1 and 2
        send(8'h00, 4'h0, 2, "R4 fi0 div1");
        send(8'h02, 4'h2, 2, "R4 fi2 div2");
        measure(4, "R9 unchanged after too-fast");

        // R3: malformed codes, precedence over the frequency test
        send(8'h05, 4'h5, 1, "R3 code05");
        send(8'h10, 4'h6, 1, "R3 code10");
        send(8'h03, 4'h7, 1, "R3 precedence reserved fi");
        send(8'h80, 4'h0, 1, "R3 code80");
        measure(4, "R9 unchanged after bad code");

        // R6 / R2: accepted switch to division 8
        s0 = stb_cnt;
        send(8'h06, 4'h0, 0, "R6 accept div8");
        settle();
        check("R8 one strobe", stb_cnt - s0, 1);
        measure(8, "R2 div8");

        // R5: division 1 allowed at 16 MHz ceiling
        send(8'h00, 4'h5, 0, "R5 fi5 div1");
        settle();
        measure(1, "R2 div1");

        // R5: limits that reject
        send(8'h00, 4'h4, 2, "R5 fi4 div1");
        send(8'h02, 4'h9, 2, "R5 fi9 div2");
        send(8'h06, 4'h7, 2, "R5 reserved fi");
        send(8'h06, 4'hE, 2, "R5 reserved fi14");
        measure(1, "R9 unchanged after R5 rejects");

        // R5: 7372 kHz below 7500 kHz ceiling
        send(8'h02, 4'hA, 0, "R5 fi10 div2");
        settle();
        measure(2, "R2 div2");

        // R8: two accepts before the switch point, last one wins
        send(8'h06, 4'h3, 0, "R5 fi3 div8");
        settle();
        measure(8, "R2 div8 again");
        wait_rise();
        s0 = stb_cnt;
        send(8'h04, 4'h6, 0, "R8 first accept");
        send(8'h00, 4'h6, 0, "R8 second accept");
        settle();
        check("R8 single strobe for two accepts", stb_cnt - s0, 1);
        measure(1, "R8 last accept wins");

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule